// File: doc/BRIEF.md
# Multi-Way TLB With Ring-Tagged Address Spaces

This block is the translation lookaside buffer of a processor memory unit. It holds five ways of translation entries. Ways 0 to 3 map 4 KB pages and are the refill ways. Way 4 maps larger pages whose size a configuration input selects. A lookup searches all five ways at once. An entry hits only when its page number matches the address and its address-space ID is nonzero and appears in one of the four byte lanes of a ring-ID register. The lane that matches gives the entry's protection ring. One cycle after the request, the block returns the physical address, the ring, the access rights and the cache mode. Instead of a translation it can return a fault cause: miss, multi-hit, privilege or prohibited.

Software-style maintenance has three ports. The entry write port installs an entry. The invalidate port clears an entry's address-space ID. The read-back port shows an entry's tag and frame. On a miss the block also reports the address of the page-table entry to fetch. The fetch itself happens outside the block, and the fetched entry comes back through the refill port. A rotating counter places each refilled entry in one of the four refill ways. When `BOOT_MAP` is set, way 4 comes out of reset as a fixed identity map that cannot be rewritten or invalidated.

Top module: `ring_tlb`

## Requirements
- R1: After reset the ring-ID register is 0x04030201 and the refill counter is 0. Every variable entry has address-space ID 0 and a zero tag and frame, so a lookup that matches nothing returns the miss cause: 1 for a fetch, 5 for data.
- R2: `rsp_valid` is high in exactly the cycle after each cycle with `lk_valid` high. The response fields belong to that request.
- R3: Ways 0-3 use 4 KB pages, with entry index `vaddr[13:12]` when SMALL_ENTRIES=4 and `vaddr[14:12]` when SMALL_ENTRIES=8. Way 4 uses the page mask 0xFFF00000 shifted left by 2*`pg4_sel` and a 2-bit index taken from bit 20+2*`pg4_sel`. On a hit, `rsp_paddr` is the entry frame ORed with the address bits below the way's page mask.
- R4: An entry hits only when its stored page equals the masked address and its ID is nonzero and equal to byte k (bits 8k+7:8k) of the ring-ID register. The lowest such k is the ring reported in `rsp_ring`.
- R5: A ring-ID write stores `{rid_wdata[31:8], 8'h01}`.
- R6: Two or more hitting ways give the multi-hit cause: 2 for a fetch, 6 for data.
- R7: With exactly one hit, an entry ring numerically below `lk_level` gives the privilege cause: 3 for a fetch, 7 for data.
- R8: `rsp_rights` is {execute, write, read} in bits 2,1,0. `rsp_cache` is 0 for bypass, 1 for write-back, 2 for write-through and 3 for isolate. An attribute a<12 grants read, grants execute if a[0] and write if a[1], and gives cache mode a[3:2]. An attribute of 13 grants read and write with isolate. Any other attribute grants nothing and gives cache 0.
- R9: `lk_kind` is 0 for load, 1 for store and 2 or 3 for fetch. A fetch keeps only execute and data keeps only read and write. If the needed right is missing, the cause is 4 for a fetch, 8 for a load and 9 for a store.
- R10: On every response, `rsp_pte_addr` is `(pt_base | vaddr>>10)` with bits 1:0 cleared.
- R11: A refill writes way (counter+1) mod 4 and then advances the counter by one.
- R12: Refills and entry writes use one entry format. The page is `vaddr & mask`, the frame is `pte & mask`, the attribute is `pte[3:0]`, and the ID is the ring-ID byte that `pte[5:4]` selects. Writes to a way above 4 or to a non-variable entry are ignored. With BOOT_MAP=1, way 4 entry i resets non-variable with page and frame i<<20, ID 1 and attribute 3.
- R13: Invalidate sets the ID of a variable entry to 0 and leaves non-variable entries untouched.
- R14: Read-back gives `rd_tag` = stored page ORed with the ID in bits 7:0, and `rd_frame` = frame ORed with the attribute in bits 3:0. Both are combinational on `rd_way`/`rd_vaddr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg4_sel | input | 2 | Page size select for way 4 |
| pt_base | input | 32 | Page-table base address |
| rid_we | input | 1 | Ring-ID register write strobe |
| rid_wdata | input | 32 | Ring-ID write data |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Lookup virtual address |
| lk_kind | input | 2 | 0 load, 1 store, 2/3 fetch |
| lk_level | input | 2 | Current privilege level |
| rsp_valid | output | 1 | Response valid |
| rsp_cause | output | 4 | 0 ok, otherwise fault cause |
| rsp_paddr | output | 32 | Physical address |
| rsp_ring | output | 2 | Ring of the hitting entry |
| rsp_rights | output | 3 | {x,w,r} after side masking |
| rsp_cache | output | 2 | Cache mode |
| rsp_pte_addr | output | 32 | Page-table entry address |
| wr_valid | input | 1 | Entry write strobe |
| wr_way | input | 3 | Entry write way |
| wr_vaddr | input | 32 | Entry write virtual address |
| wr_pte | input | 32 | Entry write data |
| inv_valid | input | 1 | Invalidate strobe |
| inv_way | input | 3 | Invalidate way |
| inv_vaddr | input | 32 | Invalidate virtual address |
| rf_valid | input | 1 | Refill strobe |
| rf_vaddr | input | 32 | Refill virtual address |
| rf_pte | input | 32 | Refill page-table entry |
| rd_way | input | 3 | Read-back way |
| rd_vaddr | input | 32 | Read-back virtual address |
| rd_tag | output | 32 | Read-back tag word |
| rd_frame | output | 32 | Read-back frame word |

## Verification
The bench builds the block with SMALL_ENTRIES=8 and BOOT_MAP=1. The 8-entry refill ways make the 3-bit index at bits 14:12 reachable, and refills land at indices 4 and 5. The fixed identity entries in way 4 show that writes and invalidates to non-variable entries change nothing. Switching `pg4_sel` shows the same address hitting and then missing in way 4 as the page size changes.

// File: rtl/ring_tlb.sv
module ring_tlb #(
  parameter int SMALL_ENTRIES = 8,
  parameter bit BOOT_MAP      = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  pg4_sel,
  input  logic [31:0] pt_base,
  input  logic        rid_we,
  input  logic [31:0] rid_wdata,
  input  logic        lk_valid,
  input  logic [31:0] lk_vaddr,
  input  logic [1:0]  lk_kind,
  input  logic [1:0]  lk_level,
  output logic        rsp_valid,
  output logic [3:0]  rsp_cause,
  output logic [31:0] rsp_paddr,
  output logic [1:0]  rsp_ring,
  output logic [2:0]  rsp_rights,
  output logic [1:0]  rsp_cache,
  output logic [31:0] rsp_pte_addr,
  input  logic        wr_valid,
  input  logic [2:0]  wr_way,
  input  logic [31:0] wr_vaddr,
  input  logic [31:0] wr_pte,
  input  logic        inv_valid,
  input  logic [2:0]  inv_way,
  input  logic [31:0] inv_vaddr,
  input  logic        rf_valid,
  input  logic [31:0] rf_vaddr,
  input  logic [31:0] rf_pte,
  input  logic [2:0]  rd_way,
  input  logic [31:0] rd_vaddr,
  output logic [31:0] rd_tag,
  output logic [31:0] rd_frame
);
  localparam int NWAYS = 5;
  localparam int BIGW  = NWAYS - 1;
  localparam int IDXW  = $clog2(SMALL_ENTRIES);
  localparam logic [2:0] LAST_WAY = 3'(BIGW);

  localparam logic [3:0] C_OK     = 4'd0;
  localparam logic [3:0] C_IMISS  = 4'd1;
  localparam logic [3:0] C_IMULTI = 4'd2;
  localparam logic [3:0] C_IPRIV  = 4'd3;
  localparam logic [3:0] C_IPROH  = 4'd4;
  localparam logic [3:0] C_DMISS  = 4'd5;
  localparam logic [3:0] C_DMULTI = 4'd6;
  localparam logic [3:0] C_DPRIV  = 4'd7;
  localparam logic [3:0] C_LPROH  = 4'd8;
  localparam logic [3:0] C_SPROH  = 4'd9;

  function automatic logic [31:0] page_mask(input int w, input logic [1:0] ps);
    if (w == BIGW) page_mask = 32'hFFF0_0000 << {ps, 1'b0};
    else           page_mask = 32'hFFFF_F000;
  endfunction

  function automatic logic [IDXW-1:0] entry_idx(input int w, input logic [31:0] va,
                                                input logic [1:0] ps);
    if (w == BIGW) entry_idx = IDXW'((va >> (20 + 2 * int'(ps))) & 32'd3);
    else           entry_idx = va[12 +: IDXW];
  endfunction

  logic [31:0] e_vpn  [NWAYS][SMALL_ENTRIES];
  logic [31:0] e_pa   [NWAYS][SMALL_ENTRIES];
  logic [7:0]  e_asid [NWAYS][SMALL_ENTRIES];
  logic [3:0]  e_attr [NWAYS][SMALL_ENTRIES];
  logic        e_var  [NWAYS][SMALL_ENTRIES];
  logic [31:0] ring_ids;
  logic [1:0]  rf_cnt;

  // unified entry update: refill wins over a port write
  logic            upd_en;
  logic [2:0]      upd_way;
  logic [31:0]     upd_va, upd_pte, upd_mask;
  logic [IDXW-1:0] upd_idx;

  always_comb begin
    upd_en  = 1'b0;
    upd_way = 3'd0;
    upd_va  = wr_vaddr;
    upd_pte = wr_pte;
    if (rf_valid) begin
      upd_en  = 1'b1;
      upd_way = {1'b0, rf_cnt + 2'd1};
      upd_va  = rf_vaddr;
      upd_pte = rf_pte;
    end else if (wr_valid && wr_way <= LAST_WAY) begin
      upd_en  = 1'b1;
      upd_way = wr_way;
    end
  end

  assign upd_mask = page_mask(int'(upd_way), pg4_sel);
  assign upd_idx  = entry_idx(int'(upd_way), upd_va, pg4_sel);

  logic            inv_en;
  logic [2:0]      inv_w;
  logic [IDXW-1:0] inv_idx;
  assign inv_en  = inv_valid && inv_way <= LAST_WAY;
  assign inv_w   = inv_en ? inv_way : 3'd0;
  assign inv_idx = entry_idx(int'(inv_w), inv_vaddr, pg4_sel);

  // parallel search
  logic [NWAYS-1:0] hit;
  logic [1:0]       hring [NWAYS];
  logic [31:0]      hpa   [NWAYS];
  logic [3:0]       hattr [NWAYS];

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic [IDXW-1:0] ix;
    logic [31:0]     m;
    logic [7:0]      id;
    logic [3:0]      lane;
    assign m  = page_mask(w, pg4_sel);
    assign ix = entry_idx(w, lk_vaddr, pg4_sel);
    assign id = e_asid[w][ix];
    for (genvar r = 0; r < 4; r++) begin : g_lane
      assign lane[r] = (ring_ids[8*r +: 8] == id);
    end
    assign hit[w]   = (id != 8'd0) && (lane != 4'd0) && (e_vpn[w][ix] == (lk_vaddr & m));
    assign hring[w] = lane[0] ? 2'd0 : lane[1] ? 2'd1 : lane[2] ? 2'd2 : 2'd3;
    assign hpa[w]   = e_pa[w][ix] | (lk_vaddr & ~m);
    assign hattr[w] = e_attr[w][ix];
  end

  logic [2:0] nhit, sel;
  always_comb begin
    nhit = 3'd0;
    sel  = 3'd0;
    for (int w = 0; w < NWAYS; w++) begin
      if (hit[w]) begin
        nhit = nhit + 3'd1;
        sel  = 3'(w);
      end
    end
  end

  logic [3:0] s_attr;
  logic       low_attr, is_fetch, a_r, a_w, a_x, need;
  logic [1:0] a_cache;
  logic [2:0] rights;
  logic [3:0] cause;

  assign s_attr   = hattr[sel];
  assign low_attr = s_attr < 4'd12;
  assign a_r      = low_attr || s_attr == 4'd13;
  assign a_w      = (low_attr && s_attr[1]) || s_attr == 4'd13;
  assign a_x      = low_attr && s_attr[0];
  assign a_cache  = low_attr ? s_attr[3:2] : (s_attr == 4'd13 ? 2'd3 : 2'd0);
  assign is_fetch = lk_kind[1];
  assign rights   = is_fetch ? {a_x, 2'b00} : {1'b0, a_w, a_r};
  assign need     = is_fetch ? a_x : (lk_kind[0] ? a_w : a_r);

  always_comb begin
    if (nhit == 3'd0)            cause = is_fetch ? C_IMISS : C_DMISS;
    else if (nhit > 3'd1)        cause = is_fetch ? C_IMULTI : C_DMULTI;
    else if (hring[sel] < lk_level) cause = is_fetch ? C_IPRIV : C_DPRIV;
    else if (!need)              cause = is_fetch ? C_IPROH : (lk_kind[0] ? C_SPROH : C_LPROH);
    else                         cause = C_OK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_ids     <= 32'h0403_0201;
      rf_cnt       <= 2'd0;
      rsp_valid    <= 1'b0;
      rsp_cause    <= C_OK;
      rsp_paddr    <= 32'd0;
      rsp_ring     <= 2'd0;
      rsp_rights   <= 3'd0;
      rsp_cache    <= 2'd0;
      rsp_pte_addr <= 32'd0;
      for (int w = 0; w < NWAYS; w++) begin
        for (int e = 0; e < SMALL_ENTRIES; e++) begin
          if (BOOT_MAP && w == BIGW) begin
            e_vpn[w][e]  <= 32'(e) << 20;
            e_pa[w][e]   <= 32'(e) << 20;
            e_asid[w][e] <= 8'd1;
            e_attr[w][e] <= 4'd3;
            e_var[w][e]  <= 1'b0;
          end else begin
            e_vpn[w][e]  <= 32'd0;
            e_pa[w][e]   <= 32'd0;
            e_asid[w][e] <= 8'd0;
            e_attr[w][e] <= 4'd0;
            e_var[w][e]  <= 1'b1;
          end
        end
      end
    end else begin
      if (rid_we) ring_ids <= {rid_wdata[31:8], 8'h01};
      if (rf_valid) rf_cnt <= rf_cnt + 2'd1;
      if (inv_en && e_var[inv_w][inv_idx]) e_asid[inv_w][inv_idx] <= 8'd0;
      if (upd_en && e_var[upd_way][upd_idx]) begin
        e_vpn[upd_way][upd_idx]  <= upd_va & upd_mask;
        e_pa[upd_way][upd_idx]   <= upd_pte & upd_mask;
        e_attr[upd_way][upd_idx] <= upd_pte[3:0];
        e_asid[upd_way][upd_idx] <= ring_ids[{upd_pte[5:4], 3'b000} +: 8];
      end
      rsp_valid <= lk_valid;
      if (lk_valid) begin
        rsp_cause    <= cause;
        rsp_paddr    <= hpa[sel];
        rsp_ring     <= hring[sel];
        rsp_rights   <= rights;
        rsp_cache    <= a_cache;
        rsp_pte_addr <= (pt_base | (lk_vaddr >> 10)) & 32'hFFFF_FFFC;
      end
    end
  end

  logic [2:0]      rd_w;
  logic [IDXW-1:0] rd_idx;
  logic            rd_ok;
  assign rd_ok    = rd_way <= LAST_WAY;
  assign rd_w     = rd_ok ? rd_way : 3'd0;
  assign rd_idx   = entry_idx(int'(rd_w), rd_vaddr, pg4_sel);
  assign rd_tag   = rd_ok ? (e_vpn[rd_w][rd_idx] | {24'd0, e_asid[rd_w][rd_idx]}) : 32'd0;
  assign rd_frame = rd_ok ? (e_pa[rd_w][rd_idx] | {28'd0, e_attr[rd_w][rd_idx]}) : 32'd0;

endmodule

// File: rtl/ring_tlb_chk.sv
module ring_tlb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        lk_valid,
  input logic [1:0]  lk_kind,
  input logic [1:0]  lk_level,
  input logic        rid_we,
  input logic [23:0] rid_hi,
  input logic        rf_valid,
  input logic        rsp_valid,
  input logic [3:0]  rsp_cause,
  input logic [1:0]  rsp_ring,
  input logic [2:0]  rsp_rights,
  input logic [31:0] ring_ids,
  input logic [1:0]  rf_cnt
);
  a_r2_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !rsp_valid);
  a_r5_rid_write: assert property (@(posedge clk) disable iff (!rst_n)
    rid_we |=> (ring_ids == {$past(rid_hi), 8'h01}));
  a_r7_ring_order: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> (rsp_cause != 4'd0 || rsp_ring >= $past(lk_level)));
  a_r9_fetch_rights: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_kind[1]) |=> (rsp_rights[1:0] == 2'b00));
  a_r9_data_rights: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_kind[1]) |=> !rsp_rights[2]);
  a_r11_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid |=> (rf_cnt == $past(rf_cnt) + 2'd1));
  a_r11_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rf_valid |=> $stable(rf_cnt));
endmodule

bind ring_tlb ring_tlb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_kind(lk_kind),
  .lk_level(lk_level), .rid_we(rid_we), .rid_hi(rid_wdata[31:8]),
  .rf_valid(rf_valid), .rsp_valid(rsp_valid), .rsp_cause(rsp_cause),
  .rsp_ring(rsp_ring), .rsp_rights(rsp_rights), .ring_ids(ring_ids),
  .rf_cnt(rf_cnt)
);

// File: tb/ring_tlb_test.sv
`timescale 1ns/1ps
module ring_tlb_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pg4_sel = 2'd0;
  logic [31:0] pt_base = 32'h8000_0000;
  logic rid_we = 1'b0;
  logic [31:0] rid_wdata = 32'd0;
  logic lk_valid = 1'b0;
  logic [31:0] lk_vaddr = 32'd0;
  logic [1:0] lk_kind = 2'd0, lk_level = 2'd0;
  logic rsp_valid;
  logic [3:0] rsp_cause;
  logic [31:0] rsp_paddr, rsp_pte_addr;
  logic [1:0] rsp_ring, rsp_cache;
  logic [2:0] rsp_rights;
  logic wr_valid = 1'b0;
  logic [2:0] wr_way = 3'd0;
  logic [31:0] wr_vaddr = 32'd0, wr_pte = 32'd0;
  logic inv_valid = 1'b0;
  logic [2:0] inv_way = 3'd0;
  logic [31:0] inv_vaddr = 32'd0;
  logic rf_valid = 1'b0;
  logic [31:0] rf_vaddr = 32'd0, rf_pte = 32'd0;
  logic [2:0] rd_way = 3'd0;
  logic [31:0] rd_vaddr = 32'd0;
  logic [31:0] rd_tag, rd_frame;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ring_tlb #(.SMALL_ENTRIES(8), .BOOT_MAP(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .pg4_sel(pg4_sel), .pt_base(pt_base),
    .rid_we(rid_we), .rid_wdata(rid_wdata),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind), .lk_level(lk_level),
    .rsp_valid(rsp_valid), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .rsp_ring(rsp_ring), .rsp_rights(rsp_rights), .rsp_cache(rsp_cache),
    .rsp_pte_addr(rsp_pte_addr),
    .wr_valid(wr_valid), .wr_way(wr_way), .wr_vaddr(wr_vaddr), .wr_pte(wr_pte),
    .inv_valid(inv_valid), .inv_way(inv_way), .inv_vaddr(inv_vaddr),
    .rf_valid(rf_valid), .rf_vaddr(rf_vaddr), .rf_pte(rf_pte),
    .rd_way(rd_way), .rd_vaddr(rd_vaddr), .rd_tag(rd_tag), .rd_frame(rd_frame)
  );

  typedef struct {
    string       req;
    logic [3:0]  cause;
    logic [31:0] pa;
    logic [1:0]  ring;
    logic [2:0]  rights;
    logic [1:0]  cache;
    logic [31:0] pte;
  } exp_t;

  exp_t sb[$];

  task automatic look(input string req, input logic [31:0] va, input logic [1:0] kind,
                      input logic [1:0] lvl, input logic [3:0] cause, input logic [31:0] pa,
                      input logic [1:0] ring, input logic [2:0] rights, input logic [1:0] cache,
                      input logic [31:0] pte);
    exp_t x;
    x.req = req; x.cause = cause; x.pa = pa; x.ring = ring;
    x.rights = rights; x.cache = cache; x.pte = pte;
    sb.push_back(x);
    lk_valid = 1'b1; lk_vaddr = va; lk_kind = kind; lk_level = lvl;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    exp_t x;
    bit ok;
    if (rst_n && rsp_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected response: actual rsp_valid=1 expected 0");
      end else begin
        x = sb.pop_front();
        ok = (rsp_cause == x.cause);
        if (x.cause == 4'd0)
          ok = ok && rsp_paddr == x.pa && rsp_ring == x.ring &&
               rsp_rights == x.rights && rsp_cache == x.cache;
        if (x.cause == 4'd4 || x.cause == 4'd8 || x.cause == 4'd9)
          ok = ok && rsp_rights == x.rights;
        if (x.cause == 4'd1 || x.cause == 4'd5)
          ok = ok && rsp_pte_addr == x.pte;
        if (!ok) begin
          errors++;
          $display("FAIL %s: actual cause=%0d pa=%h ring=%0d rights=%b cache=%0d pte=%h expected cause=%0d pa=%h ring=%0d rights=%b cache=%0d pte=%h",
                   x.req, rsp_cause, rsp_paddr, rsp_ring, rsp_rights, rsp_cache, rsp_pte_addr,
                   x.cause, x.pa, x.ring, x.rights, x.cache, x.pte);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] way, input logic [31:0] va, input logic [31:0] pte);
    wr_valid = 1'b1; wr_way = way; wr_vaddr = va; wr_pte = pte;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic inv(input logic [2:0] way, input logic [31:0] va);
    inv_valid = 1'b1; inv_way = way; inv_vaddr = va;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  task automatic refill(input logic [31:0] va, input logic [31:0] pte);
    rf_valid = 1'b1; rf_vaddr = va; rf_pte = pte;
    @(negedge clk);
    rf_valid = 1'b0;
  endtask

  task automatic ridw(input logic [31:0] d);
    rid_we = 1'b1; rid_wdata = d;
    @(negedge clk);
    rid_we = 1'b0;
  endtask

  task automatic readback(input string req, input logic [2:0] way, input logic [31:0] va,
                          input logic [31:0] tag, input logic [31:0] frame);
    rd_way = way; rd_vaddr = va;
    #1;
    checks++;
    if (rd_tag !== tag || rd_frame !== frame) begin
      errors++;
      $display("FAIL %s: actual tag=%h frame=%h expected tag=%h frame=%h",
               req, rd_tag, rd_frame, tag, frame);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state and boot map (R12)
    readback("R1 reset entry", 3'd0, 32'h0000_0000, 32'h0, 32'h0);
    readback("R12 boot entry", 3'd4, 32'h0020_0000, 32'h0020_0001, 32'h0020_0003);
    look("R1 R10 data miss", 32'h4000_1ABC, 2'd0, 2'd0, 4'd5, 0, 0, 0, 0, 32'h8010_0004);
    look("R1 fetch miss",    32'h4000_1ABC, 2'd2, 2'd0, 4'd1, 0, 0, 0, 0, 32'h8010_0004);
    look("R1 boot hit",      32'h0012_3456, 2'd0, 2'd0, 4'd0, 32'h0012_3456, 2'd0, 3'b011, 2'd0, 0);

    // R3 R8 R9 R7 R14 basic entry
    wr(3'd0, 32'h4000_3000, 32'h1234_5017);
    look("R3 R8 load hit",   32'h4000_3ABC, 2'd0, 2'd1, 4'd0, 32'h1234_5ABC, 2'd1, 3'b011, 2'd1, 0);
    look("R9 fetch rights",  32'h4000_3ABC, 2'd2, 2'd0, 4'd0, 32'h1234_5ABC, 2'd1, 3'b100, 2'd1, 0);
    look("R7 data priv",     32'h4000_3ABC, 2'd1, 2'd2, 4'd7, 0, 0, 0, 0, 0);
    look("R7 fetch priv",    32'h4000_3ABC, 2'd2, 2'd2, 4'd3, 0, 0, 0, 0, 0);
    look("R3 index bit 14",  32'h4000_7ABC, 2'd0, 2'd0, 4'd5, 0, 0, 0, 0, 32'h8010_001C);
    readback("R14 read back", 3'd0, 32'h4000_3000, 32'h4000_3002, 32'h1234_5007);

    // R8 R9 attribute decoding
    wr(3'd1, 32'h5000_2000, 32'h2222_200C);
    look("R8 attr12 load",   32'h5000_2010, 2'd0, 2'd0, 4'd8, 0, 0, 3'b000, 0, 0);
    look("R9 attr12 store",  32'h5000_2010, 2'd1, 2'd0, 4'd9, 0, 0, 3'b000, 0, 0);
    wr(3'd1, 32'h5000_2000, 32'h2222_200D);
    look("R8 attr13 load",   32'h5000_2010, 2'd0, 2'd0, 4'd0, 32'h2222_2010, 2'd0, 3'b011, 2'd3, 0);
    look("R9 attr13 fetch",  32'h5000_2010, 2'd2, 2'd0, 4'd4, 0, 0, 3'b000, 0, 0);
    wr(3'd1, 32'h5000_2000, 32'h2222_2008);
    look("R9 attr8 store",   32'h5000_2010, 2'd1, 2'd0, 4'd9, 0, 0, 3'b001, 0, 0);
    look("R8 attr8 load",    32'h5000_2010, 2'd0, 2'd0, 4'd0, 32'h2222_2010, 2'd0, 3'b001, 2'd2, 0);
    wr(3'd1, 32'h5000_2000, 32'h2222_2001);
    look("R8 attr1 fetch",   32'h5000_2010, 2'd2, 2'd0, 4'd0, 32'h2222_2010, 2'd0, 3'b100, 2'd0, 0);

    // R6 multi-hit
    wr(3'd2, 32'h4000_3000, 32'h3333_3000);
    look("R6 data multi",    32'h4000_3ABC, 2'd0, 2'd0, 4'd6, 0, 0, 0, 0, 0);
    look("R6 fetch multi",   32'h4000_3ABC, 2'd2, 2'd0, 4'd2, 0, 0, 0, 0, 0);

    // R13 invalidate
    inv(3'd2, 32'h4000_3000);
    look("R13 after inv",    32'h4000_3ABC, 2'd0, 2'd1, 4'd0, 32'h1234_5ABC, 2'd1, 3'b011, 2'd1, 0);
    readback("R13 inv clears id", 3'd2, 32'h4000_3000, 32'h4000_3000, 32'h3333_3000);
    inv(3'd4, 32'h0010_0000);
    look("R13 fixed kept",   32'h0012_3456, 2'd0, 2'd0, 4'd0, 32'h0012_3456, 2'd0, 3'b011, 2'd0, 0);

    // R12 ignored writes
    wr(3'd4, 32'h0010_0000, 32'h7770_0003);
    look("R12 fixed write",  32'h0012_3456, 2'd0, 2'd0, 4'd0, 32'h0012_3456, 2'd0, 3'b011, 2'd0, 0);
    wr(3'd5, 32'h6000_0000, 32'h6000_0003);
    look("R12 bad way",      32'h6000_0000, 2'd0, 2'd0, 4'd5, 0, 0, 0, 0, 32'h8018_0000);

    // R3 way-4 page size
    pg4_sel = 2'd3;
    look("R3 64MB page",     32'h03AB_CDEF, 2'd0, 2'd0, 4'd0, 32'h03AB_CDEF, 2'd0, 3'b011, 2'd0, 0);
    pg4_sel = 2'd0;
    look("R3 1MB page miss", 32'h03AB_CDEF, 2'd0, 2'd0, 4'd5, 0, 0, 0, 0, 32'h8000_EAF0);

    // R4 R5 ring-ID register
    ridw(32'h0506_0700);
    look("R4 id absent",     32'h4000_3ABC, 2'd0, 2'd0, 4'd5, 0, 0, 0, 0, 32'h8010_000C);
    wr(3'd3, 32'h4800_5000, 32'h4444_4031);
    look("R4 ring3",         32'h4800_5123, 2'd2, 2'd3, 4'd0, 32'h4444_4123, 2'd3, 3'b100, 2'd0, 0);
    ridw(32'h0000_0500);
    look("R4 ring1",         32'h4800_5123, 2'd2, 2'd1, 4'd0, 32'h4444_4123, 2'd1, 3'b100, 2'd0, 0);
    look("R7 ring1 lvl3",    32'h4800_5123, 2'd2, 2'd3, 4'd3, 0, 0, 0, 0, 0);
    look("R5 low byte one",  32'h0012_3456, 2'd0, 2'd0, 4'd0, 32'h0012_3456, 2'd0, 3'b011, 2'd0, 0);
    ridw(32'h0000_0000);
    look("R4 zero id",       32'h4000_3ABC, 2'd0, 2'd0, 4'd5, 0, 0, 0, 0, 32'h8010_000C);
    ridw(32'h0403_0201);

    // R11 refill rotation
    refill(32'h7000_1000, 32'h5555_5023);
    readback("R11 refill way1", 3'd1, 32'h7000_1000, 32'h7000_1003, 32'h5555_5003);
    look("R11 refill hit",   32'h7000_1FFF, 2'd0, 2'd2, 4'd0, 32'h5555_5FFF, 2'd2, 3'b011, 2'd0, 0);
    refill(32'h7000_2000, 32'h6666_6000);
    readback("R11 refill way2", 3'd2, 32'h7000_2000, 32'h7000_2001, 32'h6666_6000);
    refill(32'h7000_4000, 32'h6666_7000);
    readback("R11 refill way3", 3'd3, 32'h7000_4000, 32'h7000_4001, 32'h6666_7000);
    refill(32'h7000_5000, 32'h6666_8012);
    readback("R11 refill wrap", 3'd0, 32'h7000_5000, 32'h7000_5002, 32'h6666_8002);

    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R2 missing responses: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule